// File: doc/BRIEF.md
# Playout-Gated Jitter Buffer

This block sits between a packet receive path and a constant-rate TDM transmit path for one emulated circuit. Payload bytes are written in bursts. They are read back at the line rate in the order they were written. Reading is held back until enough bytes have built up to absorb packet delay variation. Once play-out has started, the block keeps delivering data until the storage is fully drained. It then falls back to a filling phase and waits for the start threshold again.

Three byte-valued levels are supplied as register inputs:
- a start threshold for play-out;
- an overrun watermark, which is counted as an event each time the fill level climbs above it;
- a hard ceiling, at which incoming bytes are thrown away.

An optional mode turns the watermark itself into the discard point. While the block is filling, read requests return an idle fill byte and raise an underrun flag. A configuration flag reports level settings that are inconsistent.

The controller has two states:
- `JB_FILL`: no data leaves the buffer.
- `JB_PLAY`: every read request consumes one byte.

The transitions are:
- **start**: `JB_FILL` goes to `JB_PLAY` when the fill level at the start of the cycle has reached the start threshold and is non-zero, unless a read in that same cycle empties the buffer.
- **drain**: `JB_PLAY` goes to `JB_FILL` when a read takes the last stored byte.
- **flush**: either state goes to `JB_FILL` on a flush or reset.

While in `JB_FILL` with the fill level at or above the start threshold, a read is already served in that cycle.

Top module: `jbuf_playout`

## Requirements
- R1: After reset, or in the cycle after `flush_i`, the fill level is 0, `playing_o` is 0 and `rd_valid_o` is 0. A flush leaves both event counters at their values.
- R2: While the fill level is below `start_lvl_i` (or is zero) and the block is not playing, a read request consumes nothing. In the following cycle the request yields `underrun_o`=1, `rd_valid_o`=0 and `rd_data_o` equal to `idle_byte_i`.
- R3: A read request made while the fill level is at or above `start_lvl_i`, or while `playing_o` is 1, is served. In the following cycle `rd_valid_o`=1 and the oldest stored byte is on `rd_data_o`. This holds even after the fill level has dropped below `start_lvl_i`.
- R4: When a read takes the last stored byte, `playing_o` drops to 0. Reads are refused again until the fill level has reached `start_lvl_i`.
- R5: `ovr_cnt_o` increments by one, one cycle after the registered fill level first exceeds `wmark_lvl_i`. It increments again only after the fill level has returned to the watermark or below and then exceeds it again. It saturates at all ones.
- R6: A write while the fill level is at or above `max_lvl_i` (or at `DEPTH`) is discarded. Stored bytes and the fill level are unchanged by it, and `drop_cnt_o` increments by one, saturating at all ones.
- R7: With `wmark_discard_en_i`=1, a write while the fill level exceeds `wmark_lvl_i` is discarded and counted in `drop_cnt_o`.
- R8: An accepted write and a served read in the same cycle leave the fill level unchanged.
- R9: `cfg_err_o` is 1 exactly when `start_lvl_i` > `wmark_lvl_i`, or when `wmark_lvl_i` >= `max_lvl_i`.
- R10: `clr_cnt_i` sets both event counters to zero on the next clock.
- R11: Bytes leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the buffer and return to filling |
| clr_cnt_i | input | 1 | Zero both event counters |
| wr_en_i | input | 1 | Write one payload byte |
| wr_data_i | input | DATA_W | Payload byte |
| rd_en_i | input | 1 | Line-side read request |
| rd_data_o | output | DATA_W | Read byte or idle byte, one cycle after the request |
| rd_valid_o | output | 1 | Previous request was served from storage |
| underrun_o | output | 1 | Previous request was refused |
| playing_o | output | 1 | Controller is in the play-out state |
| fill_o | output | LVL_W | Stored byte count |
| start_lvl_i | input | LVL_W | Play-out start threshold |
| wmark_lvl_i | input | LVL_W | Overrun watermark |
| max_lvl_i | input | LVL_W | Hard discard level |
| wmark_discard_en_i | input | 1 | Use the watermark as the discard level |
| idle_byte_i | input | DATA_W | Byte returned on refused reads |
| ovr_cnt_o | output | CNT_W | Overrun event count |
| drop_cnt_o | output | CNT_W | Discarded write count |
| cfg_err_o | output | 1 | Inconsistent level settings |

## Verification
A controller stuck in the wrong state appears on the very next read. An early start returns stored bytes where the idle byte and underrun flag were due. A missed drain transition leaves `playing_o` high with `fill_o` at zero. A broken pointer or fill update shows one cycle later, either as bytes out of order or as a fill count that moves on a discarded write or on a write paired with a read. Edge-detection faults in the watermark logic show as `ovr_cnt_o` climbing on every cycle spent above the watermark, instead of once per crossing.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;
    typedef enum logic {
        JB_FILL = 1'b0,
        JB_PLAY = 1'b1
    } jb_state_e;
endpackage

// File: rtl/jbuf_store.sv
module jbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_acc_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_acc_i,
    output logic [DATA_W-1:0] head_o,
    output logic [LVL_W-1:0]  fill_o
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0]  fill_q;

    always_ff @(posedge clk) begin
        if (wr_acc_i) begin
            mem[wptr_q] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (wr_acc_i) begin
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            end
            if (rd_acc_i) begin
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            end
            unique case ({wr_acc_i, rd_acc_i})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    assign head_o = mem[rptr_q];
    assign fill_o = fill_q;
endmodule

// File: rtl/jbuf_ctrl.sv
module jbuf_ctrl
    import jbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [LVL_W-1:0] fill_i,
    input  logic [LVL_W-1:0] start_lvl_i,
    input  logic [LVL_W-1:0] wmark_lvl_i,
    input  logic [LVL_W-1:0] max_lvl_i,
    input  logic             wmark_discard_en_i,
    output logic             wr_acc_o,
    output logic             rd_acc_o,
    output logic             drop_o,
    output logic             ovr_rise_o,
    output logic             playing_o
);
    localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

    jb_state_e state_q, state_d;
    logic      above_q;
    logic      ready, above, room, last_out;

    always_comb begin
        above    = fill_i > wmark_lvl_i;
        ready    = (state_q == JB_PLAY) || ((fill_i >= start_lvl_i) && (fill_i != '0));
        room     = (fill_i < max_lvl_i) && (fill_i < CAP) && !(wmark_discard_en_i && above);
        rd_acc_o = rd_en_i && ready && !flush_i;
        wr_acc_o = wr_en_i && room && !flush_i;
        drop_o   = wr_en_i && !room && !flush_i;
        ovr_rise_o = above && !above_q && !flush_i;
        last_out = rd_acc_o && !wr_acc_o && (fill_i == LVL_W'(1));
        playing_o = (state_q == JB_PLAY);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JB_FILL: if ((fill_i >= start_lvl_i) && (fill_i != '0) && !last_out) state_d = JB_PLAY;
            JB_PLAY: if (last_out) state_d = JB_FILL;
            default: state_d = JB_FILL;
        endcase
        if (flush_i) state_d = JB_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= JB_FILL;
            above_q <= 1'b0;
        end else begin
            state_q <= state_d;
            above_q <= flush_i ? 1'b0 : above;
        end
    end
endmodule

// File: rtl/jbuf_sat_cnt.sv
module jbuf_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != {W{1'b1}})) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/jbuf_playout.sv
module jbuf_playout #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              clr_cnt_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              underrun_o,
    output logic              playing_o,
    output logic [LVL_W-1:0]  fill_o,
    input  logic [LVL_W-1:0]  start_lvl_i,
    input  logic [LVL_W-1:0]  wmark_lvl_i,
    input  logic [LVL_W-1:0]  max_lvl_i,
    input  logic              wmark_discard_en_i,
    input  logic [DATA_W-1:0] idle_byte_i,
    output logic [CNT_W-1:0]  ovr_cnt_o,
    output logic [CNT_W-1:0]  drop_cnt_o,
    output logic              cfg_err_o
);
    logic              wr_acc, rd_acc, drop, ovr_rise;
    logic [DATA_W-1:0] head;

    jbuf_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .flush_i            (flush_i),
        .wr_en_i            (wr_en_i),
        .rd_en_i            (rd_en_i),
        .fill_i             (fill_o),
        .start_lvl_i        (start_lvl_i),
        .wmark_lvl_i        (wmark_lvl_i),
        .max_lvl_i          (max_lvl_i),
        .wmark_discard_en_i (wmark_discard_en_i),
        .wr_acc_o           (wr_acc),
        .rd_acc_o           (rd_acc),
        .drop_o             (drop),
        .ovr_rise_o         (ovr_rise),
        .playing_o          (playing_o)
    );

    jbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .wr_acc_i  (wr_acc),
        .wr_data_i (wr_data_i),
        .rd_acc_i  (rd_acc),
        .head_o    (head),
        .fill_o    (fill_o)
    );

    jbuf_sat_cnt #(.W(CNT_W)) u_ovr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_cnt_i),
        .inc_i (ovr_rise),
        .cnt_o (ovr_cnt_o)
    );

    jbuf_sat_cnt #(.W(CNT_W)) u_drop_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_cnt_i),
        .inc_i (drop),
        .cnt_o (drop_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_acc;
            underrun_o <= rd_en_i && !rd_acc;
            if (rd_en_i) begin
                rd_data_o <= rd_acc ? head : idle_byte_i;
            end
        end
    end

    assign cfg_err_o = (start_lvl_i > wmark_lvl_i) || (wmark_lvl_i >= max_lvl_i);
endmodule

// File: rtl/jbuf_playout_chk.sv
module jbuf_playout_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              clr_cnt_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_valid_o,
    input logic              underrun_o,
    input logic              playing_o,
    input logic [LVL_W-1:0]  fill_o,
    input logic [LVL_W-1:0]  start_lvl_i,
    input logic [LVL_W-1:0]  max_lvl_i,
    input logic              wmark_discard_en_i,
    input logic [DATA_W-1:0] idle_byte_i,
    input logic [CNT_W-1:0]  ovr_cnt_o
);
    logic gated;
    assign gated = !playing_o && ((fill_o < start_lvl_i) || (fill_o == '0));

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fill_o == '0 && !playing_o && !rd_valid_o)); // R1

    AST_GATED_NO_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && !wr_en_i && !flush_i) |=> (fill_o == $past(fill_o))); // R2

    AST_GATED_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && rd_en_i && !flush_i) |=> (underrun_o && !rd_valid_o && rd_data_o == $past(idle_byte_i))); // R2

    AST_PLAY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        playing_o |-> (fill_o != '0)); // R3

    AST_DRAIN_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (playing_o && fill_o == LVL_W'(1) && rd_en_i && !wr_en_i && !flush_i) |=> (!playing_o && fill_o == '0)); // R4

    AST_OVR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cnt_i |=> ({1'b0, ovr_cnt_o} == {1'b0, $past(ovr_cnt_o)} ||
                        {1'b0, ovr_cnt_o} == {1'b0, $past(ovr_cnt_o)} + 1'b1)); // R5

    AST_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rd_en_i && !flush_i && fill_o >= max_lvl_i) |=> (fill_o == $past(fill_o))); // R6

    AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_en_i && playing_o && !flush_i && !wmark_discard_en_i &&
         fill_o < max_lvl_i && fill_o < LVL_W'(DEPTH)) |=> (fill_o == $past(fill_o))); // R8
endmodule

bind jbuf_playout jbuf_playout_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .flush_i            (flush_i),
    .clr_cnt_i          (clr_cnt_i),
    .wr_en_i            (wr_en_i),
    .rd_en_i            (rd_en_i),
    .rd_data_o          (rd_data_o),
    .rd_valid_o         (rd_valid_o),
    .underrun_o         (underrun_o),
    .playing_o          (playing_o),
    .fill_o             (fill_o),
    .start_lvl_i        (start_lvl_i),
    .max_lvl_i          (max_lvl_i),
    .wmark_discard_en_i (wmark_discard_en_i),
    .idle_byte_i        (idle_byte_i),
    .ovr_cnt_o          (ovr_cnt_o)
);

// File: tb/jbuf_playout_tb.sv
`timescale 1ns/1ps
module jbuf_playout_tb;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = 3;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0, clr_cnt_i = 1'b0;
    logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              rd_valid_o, underrun_o, playing_o, cfg_err_o;
    logic [LVL_W-1:0]  fill_o;
    logic [LVL_W-1:0]  start_lvl_i = 5'd4, wmark_lvl_i = 5'd10, max_lvl_i = 5'd14;
    logic              wmark_discard_en_i = 1'b0;
    logic [DATA_W-1:0] idle_byte_i = 8'hFF;
    logic [CNT_W-1:0]  ovr_cnt_o, drop_cnt_o;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    jbuf_playout #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en_i = 1'b1; wr_data_i = b; tick(); wr_en_i = 1'b0;
    endtask

    task automatic pull();
        rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    endtask

    task automatic both(input logic [7:0] b);
        wr_en_i = 1'b1; rd_en_i = 1'b1; wr_data_i = b; tick();
        wr_en_i = 1'b0; rd_en_i = 1'b0;
    endtask

    task automatic do_flush();
        flush_i = 1'b1; tick(); flush_i = 1'b0;
    endtask

    task automatic do_clear();
        clr_cnt_i = 1'b1; tick(); clr_cnt_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset fill", int'(fill_o), 0);
        chk("R1 reset playing", int'(playing_o), 0);
        chk("R1 reset valid", int'(rd_valid_o), 0);
        chk("R10 reset counters", int'(ovr_cnt_o) + int'(drop_cnt_o), 0);
    endtask

    task automatic t_gate_and_drain();
        start_lvl_i = 4; wmark_lvl_i = 10; max_lvl_i = 14;
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
        pull();
        chk("R2 underrun", int'(underrun_o), 1);
        chk("R2 idle byte", int'(rd_data_o), 'hFF);
        chk("R2 no consume", int'(fill_o), 3);
        push(8'hA3);
        for (int i = 0; i < 4; i++) begin
            pull();
            chk("R3 served", int'(rd_valid_o), 1);
            chk("R11 order", int'(rd_data_o), 'hA0 + i);
            if (i == 0) chk("R3 playing", int'(playing_o), 1);
        end
        chk("R4 back to fill", int'(playing_o), 0);
        chk("R4 empty", int'(fill_o), 0);
    endtask

    task automatic t_refill();
        pull();
        chk("R4 refused when empty", int'(underrun_o), 1);
        push(8'hB0); push(8'hB1);
        pull();
        chk("R4 refused below start", int'(underrun_o), 1);
        push(8'hB2); push(8'hB3);
        pull();
        chk("R4 resumes at start", int'(rd_valid_o), 1);
        chk("R11 refill order", int'(rd_data_o), 'hB0);
        do_flush();
    endtask

    task automatic t_simul();
        start_lvl_i = 2;
        for (int i = 0; i < 3; i++) push(8'hC0 + 8'(i));
        pull();
        chk("R8 pre fill", int'(fill_o), 2);
        for (int i = 0; i < 3; i++) begin
            both(8'hC3 + 8'(i));
            chk("R8 net zero", int'(fill_o), 2);
            chk("R11 simul order", int'(rd_data_o), 'hC1 + i);
        end
        do_flush();
    endtask

    task automatic t_overrun_and_max();
        do_clear();
        start_lvl_i = 15; wmark_lvl_i = 4; max_lvl_i = 8;
        for (int i = 0; i < 5; i++) push(8'hD0 + 8'(i));
        tick();
        chk("R5 first crossing", int'(ovr_cnt_o), 1);
        for (int i = 5; i < 8; i++) push(8'hD0 + 8'(i));
        tick();
        chk("R5 once per crossing", int'(ovr_cnt_o), 1);
        push(8'hEE);
        chk("R6 fill held", int'(fill_o), 8);
        chk("R6 drop counted", int'(drop_cnt_o), 1);
        start_lvl_i = 2;
        for (int i = 0; i < 4; i++) pull();
        tick();
        push(8'hD8);
        tick();
        chk("R5 second crossing", int'(ovr_cnt_o), 2);
        pull();
        chk("R6 contents intact", int'(rd_data_o), 'hD4);
        do_flush();
        chk("R1 flush keeps ovr", int'(ovr_cnt_o), 2);
        chk("R1 flush keeps drop", int'(drop_cnt_o), 1);
        chk("R1 flush fill", int'(fill_o), 0);
        do_clear();
        chk("R10 clear", int'(ovr_cnt_o) + int'(drop_cnt_o), 0);
        start_lvl_i = 15; max_lvl_i = 2; wmark_lvl_i = 10;
        for (int i = 0; i < 12; i++) push(8'h11);
        chk("R6 drop saturates", int'(drop_cnt_o), 7);
        do_flush(); do_clear();
    endtask

    task automatic t_wmark_mode();
        start_lvl_i = 15; wmark_lvl_i = 3; max_lvl_i = 8; wmark_discard_en_i = 1'b1;
        for (int i = 0; i < 6; i++) push(8'h20 + 8'(i));
        chk("R7 fill capped", int'(fill_o), 4);
        chk("R7 drops", int'(drop_cnt_o), 2);
        wmark_discard_en_i = 1'b0;
        do_flush(); do_clear();
    endtask

    task automatic t_cfg();
        start_lvl_i = 5; wmark_lvl_i = 4; max_lvl_i = 8; #1;
        chk("R9 start above wmark", int'(cfg_err_o), 1);
        start_lvl_i = 2; wmark_lvl_i = 8; #1;
        chk("R9 wmark at max", int'(cfg_err_o), 1);
        wmark_lvl_i = 4; #1;
        chk("R9 consistent", int'(cfg_err_o), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_gate_and_drain();
        t_refill();
        t_simul();
        t_overrun_and_max();
        t_wmark_mode();
        t_cfg();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule